// File: doc/BRIEF.md
# Synchronous Buck Gate Timing Generator

This block sits between the PWM comparator of a voltage-mode buck controller and the two gate drivers of its synchronous power stage. Every oscillator tick it decides whether the high-side switch conducts during the coming period. The high-side enable is released when the PWM request falls or when a duty ceiling is reached, whichever comes first. The low-side switch carries the inductor current for the rest of the period.

Each hand-over between the switches passes through a wait state in which both enables are low. The wait ends when the gate driver feedback says the outgoing switch is off. If that feedback never comes, the wait ends after a bounded number of clocks and a sticky flag records it. While the low side conducts, a switch-node comparator is watched for overcurrent after a short blanking window. A hit stops all switching until reset. A strobe marks the first high-side pulse after start, when an external sampler checks that input power is present. A shutdown request forces both switches off at once.

Top module: `buck_gate_sequencer`

## Requirements
- R1: While reset is held and after it is released, with no period tick, `hs_en`, `ls_en`, `ocp_fault`, `vin_sample_stb` and `dt_timeout` are all 0.
- R2: `hs_en` and `ls_en` are never 1 together. `hs_en` rises only after a clock in which both enables were 0 and `lg_off_fb` was 1, or after the dead-time limit expired.
- R3: `ls_en` rises only after a clock in which both enables were 0 and both `hg_off_fb` and `sw_low` were 1, or after the dead-time limit expired.
- R4: If the expected off feedback stays 0, the block waits 16 clocks with both enables low and then turns the other switch on. It also sets `dt_timeout`, which stays 1 until reset.
- R5: When `pwm_req` is 1 at a `period_tick`, the low side turns off and the high side turns on once the feedback allows. The high side turns off on the clock after `pwm_req` is seen at 0.
- R6: `hs_en` is never 1 for more than 30 consecutive clocks, which is 75 % of the 40-clock period. This holds even if `pwm_req` stays 1.
- R7: When `pwm_req` is 0 at a `period_tick`, the high side is skipped and `ls_en` stays 1 for the whole period. The overcurrent check stays active during that period.
- R8: While `ls_en` is 1 and blanking is over, an `ocp_cmp` value of 1 drives both enables to 0 on the next clock and sets `ocp_fault`. Both enables then stay 0 and the fault stays 1 until reset, whatever the ticks and requests.
- R9: `ocp_cmp` has no effect during the first 4 clocks after `ls_en` rises. It is taken into account from the 5th clock on.
- R10: A `shutdown` of 1 drives both enables to 0 on the next clock. Switching restarts only at a `period_tick` seen while `shutdown` is 0. Releasing `shutdown` alone does not restart it.
- R11: `vin_sample_stb` is a one-clock pulse that coincides with the first clock of `hs_en` after reset or after a shutdown. It does not pulse on later high-side pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_tick | input | 1 | One-clock pulse at the start of each switching period |
| pwm_req | input | 1 | PWM comparator output, 1 requests high-side conduction |
| lg_off_fb | input | 1 | 1 when the low-side gate is confirmed off |
| hg_off_fb | input | 1 | 1 when the high-side gate is confirmed off |
| sw_low | input | 1 | 1 when the switch node has fallen low |
| ocp_cmp | input | 1 | 1 when the switch node is below the negative current limit |
| shutdown | input | 1 | 1 requests both switches off |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| ocp_fault | output | 1 | Latched overcurrent fault |
| vin_sample_stb | output | 1 | Input-presence sampling strobe on the first high-side pulse |
| dt_timeout | output | 1 | Sticky flag: a dead-time wait ended by timeout |

## Verification
The hardest cases to reach are the dead-time timeouts and the blanking boundary. In normal use the feedback always arrives, and the overcurrent comparator only matters at one exact clock. The bench drives the gate feedback as a model of the outputs and can hold any one feedback stuck at 0. It counts clocks from the period tick, so an overcurrent pulse can be placed on the last blanked clock and, in a later period, on the first clock that counts.

// File: rtl/gs_pkg.sv
`timescale 1ns/1ps
package gs_pkg;
  typedef enum logic [2:0] {
    GS_OFF,
    GS_LOW,
    GS_WAIT_LO,
    GS_HIGH,
    GS_WAIT_HI,
    GS_FAULT
  } gs_state_t;
endpackage

// File: rtl/gs_span_counter.sv
`timescale 1ns/1ps
// Counts clocks while run is high, clears when low, saturates at LIMIT-1.
module gs_span_counter #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic reached
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LAST) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign reached = run && (cnt_q == LAST);

  AST_SPAN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && reached) |=> (!run || reached)); // R9
endmodule

// File: rtl/buck_gate_sequencer.sv
`timescale 1ns/1ps
module buck_gate_sequencer #(
  parameter int unsigned PERIOD_CLKS  = 40,
  parameter int unsigned DUTY_MAX_PCT = 75,
  parameter int unsigned DT_LIMIT     = 16,
  parameter int unsigned BLANK_CLKS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic period_tick,
  input  logic pwm_req,
  input  logic lg_off_fb,
  input  logic hg_off_fb,
  input  logic sw_low,
  input  logic ocp_cmp,
  input  logic shutdown,
  output logic hs_en,
  output logic ls_en,
  output logic ocp_fault,
  output logic vin_sample_stb,
  output logic dt_timeout
);
  import gs_pkg::*;

  localparam int unsigned ON_MAX = (PERIOD_CLKS * DUTY_MAX_PCT) / 100;
  localparam int unsigned LW     = $clog2(ON_MAX + 2);

  // reset synchronizer: asserts asynchronously, releases on clk
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  gs_state_t state_q, state_d;
  logic      dt_expired, duty_hit, blank_done;
  logic      dt_take;
  logic      dt_flag_q;
  logic      armed_q, armed_d, armed_en;

  gs_span_counter #(.LIMIT(DT_LIMIT)) u_dead_wait (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     ((state_q == GS_WAIT_LO) || (state_q == GS_WAIT_HI)),
    .reached (dt_expired)
  );

  gs_span_counter #(.LIMIT(ON_MAX)) u_duty_cap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (state_q == GS_HIGH),
    .reached (duty_hit)
  );

  gs_span_counter #(.LIMIT(BLANK_CLKS + 1)) u_ocp_blank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (state_q == GS_LOW),
    .reached (blank_done)
  );

  // next state
  always_comb begin
    state_d = state_q;
    dt_take = 1'b0;
    if (state_q == GS_FAULT) begin
      state_d = GS_FAULT;
    end else if (shutdown) begin
      state_d = GS_OFF;
    end else begin
      case (state_q)
        GS_OFF:
          if (period_tick) state_d = pwm_req ? GS_WAIT_LO : GS_WAIT_HI;
        GS_LOW:
          if (blank_done && ocp_cmp)         state_d = GS_FAULT;
          else if (period_tick && pwm_req)   state_d = GS_WAIT_LO;
        GS_WAIT_LO:
          if (lg_off_fb) begin
            state_d = GS_HIGH;
          end else if (dt_expired) begin
            state_d = GS_HIGH;
            dt_take = 1'b1;
          end
        GS_HIGH:
          if (!pwm_req || duty_hit) state_d = GS_WAIT_HI;
        GS_WAIT_HI:
          if (hg_off_fb && sw_low) begin
            state_d = GS_LOW;
          end else if (dt_expired) begin
            state_d = GS_LOW;
            dt_take = 1'b1;
          end
        default: state_d = GS_OFF;
      endcase
    end
  end

  always_comb begin
    armed_en = shutdown || (state_q == GS_HIGH);
    armed_d  = shutdown;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= GS_OFF;
      dt_flag_q <= 1'b0;
      armed_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      if (dt_take)  dt_flag_q <= 1'b1;
      if (armed_en) armed_q   <= armed_d;
    end
  end

  assign hs_en          = (state_q == GS_HIGH);
  assign ls_en          = (state_q == GS_LOW);
  assign ocp_fault      = (state_q == GS_FAULT);
  assign dt_timeout     = dt_flag_q;
  assign vin_sample_stb = armed_q && (state_q == GS_HIGH);

  // run-length monitor for the duty ceiling
  logic [LW-1:0] hs_run_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)            hs_run_q <= '0;
    else if (!hs_en)            hs_run_q <= '0;
    else if (hs_run_q <= LW'(ON_MAX)) hs_run_q <= hs_run_q + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(hs_en && ls_en)); // R2
  AST_HS_AFTER_LOFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hs_en) |-> $past(!ls_en && (lg_off_fb || dt_expired))); // R2
  AST_LS_AFTER_HOFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ls_en) |-> $past(!hs_en && ((hg_off_fb && sw_low) || dt_expired))); // R3
  AST_DT_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dt_timeout |=> dt_timeout); // R4
  AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hs_en |-> (hs_run_q < LW'(ON_MAX))); // R6
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ocp_fault |=> (ocp_fault && !hs_en && !ls_en)); // R8
  AST_OCP_BLANKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ocp_fault) |-> $past(ls_en && blank_done && ocp_cmp)); // R9
  AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    shutdown |=> (!hs_en && !ls_en)); // R10
  AST_STB_WITH_HS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vin_sample_stb |-> hs_en); // R11
endmodule

// File: tb/buck_gate_sequencer_tb_top.sv
`timescale 1ns/1ps
module buck_gate_sequencer_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, period_tick, pwm_req, ocp_cmp, shutdown;
  logic lg_stuck, hg_stuck, sw_stuck;
  logic hs_en, ls_en, ocp_fault, vin_sample_stb, dt_timeout;
  logic lg_off_fb, hg_off_fb, sw_low;

  // gate driver feedback model, with optional stuck-off faults
  assign lg_off_fb = !ls_en && !lg_stuck;
  assign hg_off_fb = !hs_en && !hg_stuck;
  assign sw_low    = !hs_en && !sw_stuck;

  buck_gate_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .pwm_req(pwm_req),
    .lg_off_fb(lg_off_fb), .hg_off_fb(hg_off_fb), .sw_low(sw_low),
    .ocp_cmp(ocp_cmp), .shutdown(shutdown), .hs_en(hs_en), .ls_en(ls_en),
    .ocp_fault(ocp_fault), .vin_sample_stb(vin_sample_stb), .dt_timeout(dt_timeout)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic hs_s [40];
  logic ls_s [40];
  logic stb_s[40];
  logic flt_s[40];
  logic dt_s [40];

  // {req, pwm width, expected hs clocks, expected strobes}
  localparam int VEC [6][4] = '{
    '{1,  5,  5, 1},
    '{1, 12, 12, 0},
    '{1, 30, 30, 0},
    '{1, 35, 30, 0},
    '{0,  0,  0, 0},
    '{1,  1,  1, 0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cnt(input logic a[40], input int lo, input int hi);
    int s = 0;
    for (int i = lo; i <= hi; i++) s += int'(a[i]);
    return s;
  endfunction

  function automatic int both(input int lo, input int hi);
    int s = 0;
    for (int i = lo; i <= hi; i++) s += int'(hs_s[i] && ls_s[i]);
    return s;
  endfunction

  // one 40-clock period; sample first, then drive, at each falling edge
  task automatic run_period(input bit req, input int w, input int ocp_lo, input int ocp_hi,
                            input int sd_lo, input int sd_hi);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      hs_s[i]  = hs_en;
      ls_s[i]  = ls_en;
      stb_s[i] = vin_sample_stb;
      flt_s[i] = ocp_fault;
      dt_s[i]  = dt_timeout;
      period_tick = (i == 0);
      pwm_req     = req && (i <= w);
      ocp_cmp     = (i >= ocp_lo) && (i <= ocp_hi);
      shutdown    = (i >= sd_lo) && (i <= sd_hi);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; period_tick = 1'b0; pwm_req = 1'b0; ocp_cmp = 1'b0; shutdown = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #4000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    lg_stuck = 1'b0; hg_stuck = 1'b0; sw_stuck = 1'b0;
    rst_n = 1'b0;
    do_reset();

    // R1 reset state
    chk("R1 hs_en", int'(hs_en), 0);
    chk("R1 ls_en", int'(ls_en), 0);
    chk("R1 ocp_fault", int'(ocp_fault), 0);
    chk("R1 strobe", int'(vin_sample_stb), 0);
    chk("R1 dt_timeout", int'(dt_timeout), 0);
    repeat (5) @(negedge clk);
    chk("R1 idle enables", int'(hs_en || ls_en), 0);

    // table of periods
    for (int v = 0; v < 6; v++) begin
      run_period(VEC[v][0] != 0, VEC[v][1], 99, 0, 99, 0);
      @(negedge clk);
      hs_s[0] = hs_en;
      chk((VEC[v][0] == 0) ? "R7 hs skipped" : (VEC[v][1] > 30) ? "R6 duty cap" : "R5 hs width",
          cnt(hs_s, 0, 39), VEC[v][2]);
      chk("R2 overlap", both(0, 39), 0);
      chk("R11 strobe count", cnt(stb_s, 1, 39), VEC[v][3]);
      if (VEC[v][0] == 0) chk("R7 ls whole period", cnt(ls_s, 1, 39), 39);
      else                chk("R3 ls at period end", int'(ls_s[39]), 1);
      repeat (39) @(negedge clk);
    end
    chk("R4 no timeout with feedback", int'(dt_timeout), 0);

    // R9 blanking: ocp on the first 4 low-side clocks is ignored
    run_period(1, 3, 6, 9, 99, 0);
    chk("R9 ocp blanked", cnt(flt_s, 1, 39), 0);
    chk("R9 ls kept", int'(ls_s[39]), 1);

    // R3 high-gate feedback stuck: low side waits 16 clocks
    hg_stuck = 1'b1;
    run_period(1, 3, 99, 0, 99, 0);
    hg_stuck = 1'b0;
    chk("R3 ls held during wait", int'(ls_s[20]), 0);
    chk("R4 ls after timeout", int'(ls_s[21]), 1);
    chk("R4 dt flag before", int'(dt_s[20]), 0);
    chk("R4 dt flag set", int'(dt_s[21]), 1);

    // R3 switch node stuck high
    sw_stuck = 1'b1;
    run_period(1, 3, 99, 0, 99, 0);
    sw_stuck = 1'b0;
    chk("R3 sw_low gating", int'(ls_s[20]), 0);
    chk("R3 sw_low timeout", int'(ls_s[21]), 1);

    // R2 low-gate feedback stuck: high side waits 16 clocks
    lg_stuck = 1'b1;
    run_period(1, 25, 99, 0, 99, 0);
    lg_stuck = 1'b0;
    chk("R2 hs held during wait", int'(hs_s[16]), 0);
    chk("R2 hs after timeout", int'(hs_s[17]), 1);
    chk("R4 dt sticky", int'(dt_s[39]), 1);

    // R10 shutdown
    run_period(1, 20, 99, 0, 5, 39);
    chk("R10 hs before shutdown", int'(hs_s[5]), 1);
    chk("R10 hs off next clock", int'(hs_s[6]), 0);
    chk("R10 ls off", cnt(ls_s, 6, 39), 0);
    run_period(1, 20, 99, 0, 0, 39);
    chk("R10 tick ignored in shutdown", cnt(hs_s, 0, 39) + cnt(ls_s, 0, 39), 0);
    run_period(1, 20, 99, 0, 0, 10);
    chk("R10 release without tick", cnt(hs_s, 0, 39) + cnt(ls_s, 0, 39), 0);
    run_period(1, 5, 99, 0, 99, 0);
    chk("R11 strobe rearmed", int'(stb_s[2]), 1);
    chk("R10 restart width", cnt(hs_s, 1, 39), 5);

    // R8 overcurrent on the first unblanked clock
    run_period(1, 3, 10, 10, 99, 0);
    chk("R9 not yet faulted", int'(flt_s[10]), 0);
    chk("R8 fault latched", int'(flt_s[11]), 1);
    chk("R8 enables off", cnt(hs_s, 11, 39) + cnt(ls_s, 11, 39), 0);
    run_period(1, 10, 99, 0, 99, 0);
    chk("R8 no switching", cnt(hs_s, 0, 39) + cnt(ls_s, 0, 39), 0);
    chk("R8 fault held", cnt(flt_s, 0, 39), 40);

    do_reset();
    chk("R1 fault cleared", int'(ocp_fault), 0);
    chk("R1 dt cleared", int'(dt_timeout), 0);

    // R7 overcurrent checked in a skipped period
    run_period(1, 3, 99, 0, 99, 0);
    run_period(0, 0, 5, 5, 99, 0);
    chk("R7 ls on before hit", int'(ls_s[5]), 1);
    chk("R7 fault in skipped period", int'(flt_s[6]), 1);
    chk("R8 ls dropped", int'(ls_s[6]), 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule